// File: doc/BRIEF.md
# Cache Tag RAM with Valid-Qualified Comparator

This block is the tag directory of a secondary cache. An index input picks one entry. The entry's stored tag is compared with an incoming tag, and an active-high hit output is raised when the two agree. Each entry carries a tag field and three status flags: valid, dirty and write-through. Reads and the hit comparison are combinational from the index and tag inputs. Writes land on a rising clock edge.

A mode input sets how the status flags are used. With the mode low, the flags have fixed meanings: a write marks the entry valid, and a hit counts only on a valid entry. With the mode high, the three flags are plain user storage and do not affect the hit. A synchronous active-low clear wipes the status of every entry in one edge and leaves the tags in place. A transfer-acknowledge output is built from the hit, the status flags and two external inputs, so the cache controller can end a bus cycle without further decoding. A standby input blocks writes and holds the hit and acknowledge outputs low.

The array has 2^IDX_W entries. The default is IDX_W = 8, which gives 256 entries. IDX_W = 14 gives the full 16K-entry array.

Top module: `cache_tag_ram`

## Requirements
- R1: The array holds 2^IDX_W entries, each with a TAG_W-bit tag and three status flags. Every index, including 0 and the highest, stores and returns its own contents.
- R2: rd_tag, rd_vld, rd_dty, rd_wt and match follow idx and tag_in combinationally, in the same cycle and with no clock edge.
- R3: match is high only when the stored tag at idx equals tag_in. With mode_user low, match is also forced low when the entry's valid flag is clear.
- R4: A write takes effect only at a rising clk edge with wr_en high, pwr_dn low and rst_n high. It stores tag_in at idx. With mode_user low, it sets valid to 1, dirty to wr_dty and write-through to wr_wt.
- R5: When rst_n is low at a rising edge, the valid, dirty and write-through flags of every entry read 0 from the next cycle. Stored tags are unchanged.
- R6: When rst_n is low and a write is requested at the same edge, the clear wins for the status flags: the entry reads valid=0, dirty=0 and write-through=0. The tag part of the write still lands.
- R7: With mode_user high, a write loads the flags from wr_vld, wr_dty and wr_wt as given. match ignores the valid flag.
- R8: While pwr_dn is high, writes are ignored, match and xfer_ack are held low, and the stored contents are kept.
- R9: With mode_user low, xfer_ack = ack_en AND match AND valid AND NOT (cyc_wr AND write-through).
- R10: With mode_user high, xfer_ack = ack_en AND match. The status flags have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and for the bulk clear |
| rst_n | input | 1 | Synchronous active-low clear of all status flags |
| pwr_dn | input | 1 | Standby: blocks writes and quiets match and xfer_ack |
| mode_user | input | 1 | 0: flags have fixed meanings; 1: flags are user storage |
| idx | input | IDX_W | Entry index |
| tag_in | input | TAG_W | Tag to compare and to write |
| wr_en | input | 1 | Write request, taken at the rising edge |
| wr_vld | input | 1 | Valid flag write data (user mode only) |
| wr_dty | input | 1 | Dirty flag write data |
| wr_wt | input | 1 | Write-through flag write data |
| ack_en | input | 1 | External enable for the acknowledge term |
| cyc_wr | input | 1 | The current bus cycle is a write |
| rd_tag | output | TAG_W | Stored tag at idx |
| rd_vld | output | 1 | Stored valid flag at idx |
| rd_dty | output | 1 | Stored dirty flag at idx |
| rd_wt | output | 1 | Stored write-through flag at idx |
| match | output | 1 | Qualified tag hit |
| xfer_ack | output | 1 | Transfer acknowledge |

## Verification
The clocked properties assume that rst_n is driven low at the first edge, so every status flag has a known value before any hit is judged. They also assume that tags are only compared at indices that have been written since time zero. They take idx, tag_in and the control inputs to be steady around each rising edge. The stimulus therefore pulses rst_n from time zero and only probes entries it has written. It changes every input half a cycle away from the sampling edge. The checks on stable contents across standby keep idx fixed over the two cycles being compared.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    // Status flags kept per entry; bit order {vld, dty, wt}.
    typedef struct packed {
        logic vld;
        logic dty;
        logic wt;
    } tag_status_t;

    localparam int STATUS_W = $bits(tag_status_t);

endpackage

// File: rtl/tag_store.sv
module tag_store #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [TAG_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [TAG_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] mem_d [DEPTH];
    logic [TAG_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    // Read port is purely combinational.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/status_bank.sv
module status_bank
    import cache_tag_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  tag_status_t      wdata,
    input  logic [IDX_W-1:0] raddr,
    output tag_status_t      rdata
);
    localparam int DEPTH = 1 << IDX_W;

    tag_status_t st_all [DEPTH];

    // One flop set per entry so the clear reaches all of them in parallel.
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        tag_status_t ent_d;
        tag_status_t ent_q;

        always_comb begin
            ent_d = ent_q;
            if (!clr_n) begin
                ent_d = '0;
            end else if (we && (waddr == IDX_W'(e))) begin
                ent_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            ent_q <= ent_d;
        end

        assign st_all[e] = ent_q;
    end

    assign rdata = st_all[raddr];

    // R5: the cycle after a clear edge, whatever entry is addressed reads zero.
    a_r5_bulk_clear: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(clr_n) |-> (rdata == '0));

endmodule

// File: rtl/tag_compare.sv
module tag_compare
    import cache_tag_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] probe_tag,
    input  tag_status_t      stat,
    input  logic             mode_user,
    input  logic             pwr_dn,
    input  logic             ack_en,
    input  logic             cyc_wr,
    output logic             hit,
    output logic             ack
);
    logic tags_eq;
    logic vld_ok;
    logic wt_block;

    always_comb begin
        tags_eq  = (stored_tag == probe_tag);
        vld_ok   = mode_user || stat.vld;
        wt_block = !mode_user && cyc_wr && stat.wt;
        hit      = !pwr_dn && tags_eq && vld_ok;
        ack      = hit && ack_en && !wt_block;
    end

endmodule

// File: rtl/cache_tag_ram.sv
module cache_tag_ram
    import cache_tag_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             mode_user,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             wr_en,
    input  logic             wr_vld,
    input  logic             wr_dty,
    input  logic             wr_wt,
    input  logic             ack_en,
    input  logic             cyc_wr,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld,
    output logic             rd_dty,
    output logic             rd_wt,
    output logic             match,
    output logic             xfer_ack
);
    logic        wr_go;
    tag_status_t st_wdata;
    tag_status_t st_rd;

    always_comb begin
        wr_go        = wr_en && !pwr_dn;
        st_wdata.vld = mode_user ? wr_vld : 1'b1;
        st_wdata.dty = wr_dty;
        st_wdata.wt  = wr_wt;
    end

    tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk   (clk),
        .we    (wr_go),
        .waddr (idx),
        .wdata (tag_in),
        .raddr (idx),
        .rdata (rd_tag)
    );

    status_bank #(.IDX_W(IDX_W)) u_stat (
        .clk   (clk),
        .clr_n (rst_n),
        .we    (wr_go),
        .waddr (idx),
        .wdata (st_wdata),
        .raddr (idx),
        .rdata (st_rd)
    );

    tag_compare #(.TAG_W(TAG_W)) u_cmp (
        .stored_tag (rd_tag),
        .probe_tag  (tag_in),
        .stat       (st_rd),
        .mode_user  (mode_user),
        .pwr_dn     (pwr_dn),
        .ack_en     (ack_en),
        .cyc_wr     (cyc_wr),
        .hit        (match),
        .ack        (xfer_ack)
    );

    assign rd_vld = st_rd.vld;
    assign rd_dty = st_rd.dty;
    assign rd_wt  = st_rd.wt;

    // R3: in fixed-meaning mode a hit needs a valid entry.
    a_r3_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_user && match) |-> rd_vld);

    // R4: an accepted write is visible at the same index one cycle later.
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !$past(pwr_dn) && $past(rst_n) && (idx == $past(idx)))
        |-> (rd_tag == $past(tag_in)));

    // R4: in fixed-meaning mode an accepted write marks the entry valid.
    a_r4_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !$past(pwr_dn) && $past(rst_n) && !$past(mode_user)
         && (idx == $past(idx))) |-> rd_vld);

    // R8: standby keeps match and acknowledge low.
    a_r8_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |-> (!match && !xfer_ack));

    // R8: a write request during standby leaves the entry untouched.
    a_r8_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_dn) && $past(wr_en) && $past(rst_n) && (idx == $past(idx)))
        |-> ((rd_tag == $past(rd_tag)) && (st_rd == $past(st_rd))));

    // R9: acknowledge never appears without a hit and the external enable.
    a_r9_ack_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |-> (match && ack_en));

    // R9: a write cycle on a write-through entry is not acknowledged.
    a_r9_wt_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_user && cyc_wr && rd_wt) |-> !xfer_ack);

endmodule

// File: tb/sim_cache_tag_ram.sv
module sim_cache_tag_ram;
    localparam int IDX_W = 8;
    localparam int TAG_W = 12;
    localparam int DEPTH = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_dn = 1'b0;
    logic             mode_user = 1'b0;
    logic [IDX_W-1:0] idx = '0;
    logic [TAG_W-1:0] tag_in = '0;
    logic             wr_en = 1'b0;
    logic             wr_vld = 1'b0;
    logic             wr_dty = 1'b0;
    logic             wr_wt = 1'b0;
    logic             ack_en = 1'b0;
    logic             cyc_wr = 1'b0;
    logic [TAG_W-1:0] rd_tag;
    logic             rd_vld, rd_dty, rd_wt, match, xfer_ack;

    always #4 clk = ~clk;

    cache_tag_ram #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .mode_user(mode_user),
        .idx(idx), .tag_in(tag_in), .wr_en(wr_en), .wr_vld(wr_vld),
        .wr_dty(wr_dty), .wr_wt(wr_wt), .ack_en(ack_en), .cyc_wr(cyc_wr),
        .rd_tag(rd_tag), .rd_vld(rd_vld), .rd_dty(rd_dty), .rd_wt(rd_wt),
        .match(match), .xfer_ack(xfer_ack)
    );

    // Reference contents built from the requirements. Status order {vld,dty,wt}.
    logic [TAG_W-1:0] m_tag [DEPTH];
    logic [2:0]       m_st  [DEPTH];

    typedef struct {
        string            req;
        logic [TAG_W-1:0] tag;
        logic [2:0]       st;
        logic             hit;
        logic             ack;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    initial begin
        for (int i = 0; i < DEPTH; i++) m_st[i] = 3'b000;
    end

    // Driver: probe the current inputs and queue the expected outputs.
    task automatic probe_now(input string req, input int i, input logic [TAG_W-1:0] t);
        exp_t e;
        logic v;
        idx    = IDX_W'(i);
        tag_in = t;
        e.req  = req;
        e.tag  = m_tag[i];
        e.st   = m_st[i];
        v      = m_st[i][2];
        e.hit  = !pwr_dn && (m_tag[i] == t) && (mode_user || v);
        if (mode_user) e.ack = e.hit && ack_en;
        else           e.ack = e.hit && ack_en && v && !(cyc_wr && m_st[i][0]);
        exp_q.push_back(e);
        #2;
    endtask

    task automatic probe(input string req, input int i, input logic [TAG_W-1:0] t);
        @(negedge clk);
        probe_now(req, i, t);
    endtask

    task automatic write(input int i, input logic [TAG_W-1:0] t,
                         input logic v, input logic d, input logic w);
        @(negedge clk);
        idx = IDX_W'(i); tag_in = t; wr_vld = v; wr_dty = d; wr_wt = w; wr_en = 1'b1;
        @(posedge clk);
        if (!pwr_dn) begin
            m_tag[i] = t;
            m_st[i]  = mode_user ? {v, d, w} : {1'b1, d, w};
            if (!rst_n) m_st[i] = 3'b000;
        end
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) m_st[k] = 3'b000;
        end
        #1 wr_en = 1'b0;
    endtask

    // Monitor: pop each expectation and compare it with the live outputs.
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() != 0);
            #1;
            e = exp_q.pop_front();
            total++;
            if (rd_tag !== e.tag || {rd_vld, rd_dty, rd_wt} !== e.st ||
                match !== e.hit || xfer_ack !== e.ack) begin
                bad++;
                $display("FAIL %s: actual tag=%h st=%b hit=%b ack=%b expected tag=%h st=%b hit=%b ack=%b",
                         e.req, rd_tag, {rd_vld, rd_dty, rd_wt}, match, xfer_ack,
                         e.tag, e.st, e.hit, e.ack);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R5: clear at the first edges, then a write gives known contents
        @(posedge clk); @(posedge clk);
        #1 rst_n = 1'b1;
        write(5, 12'hABC, 1'b0, 1'b1, 1'b0);
        probe("R4 write sets valid and flags", 5, 12'hABC);
        probe("R3 mismatch gives no hit", 5, 12'hABD);
        // R1 boundary indices
        write(0, 12'hFFF, 1'b0, 1'b0, 1'b0);
        write(DEPTH - 1, 12'h123, 1'b0, 1'b0, 1'b1);
        probe("R1 lowest index", 0, 12'hFFF);
        probe("R1 highest index", DEPTH - 1, 12'h123);
        // R2: switch index mid-cycle without a clock edge
        probe_now("R2 combinational read", 5, 12'hABC);
        // R9 acknowledge terms
        ack_en = 1'b1; cyc_wr = 1'b0;
        probe("R9 read cycle ack on write-through entry", DEPTH - 1, 12'h123);
        cyc_wr = 1'b1;
        probe("R9 write cycle blocked by write-through", DEPTH - 1, 12'h123);
        probe("R9 write cycle ack on copy-back entry", 5, 12'hABC);
        ack_en = 1'b0;
        probe("R9 enable low gives no ack", 5, 12'hABC);
        ack_en = 1'b1;
        // R8 standby
        pwr_dn = 1'b1;
        write(5, 12'h555, 1'b0, 1'b0, 1'b1);
        probe("R8 standby quiets hit and ack", 5, 12'hABC);
        pwr_dn = 1'b0;
        probe("R8 contents kept after standby", 5, 12'hABC);
        // R6: clear and write at one edge
        rst_n = 1'b0;
        write(7, 12'h777, 1'b0, 1'b1, 1'b1);
        rst_n = 1'b1;
        probe("R6 tag lands status cleared", 7, 12'h777);
        probe("R5 bulk clear keeps tag drops valid", 5, 12'hABC);
        probe("R5 bulk clear at highest index", DEPTH - 1, 12'h123);
        // R7 / R10 user mode
        mode_user = 1'b1;
        probe("R7 hit ignores valid in user mode", 5, 12'hABC);
        write(9, 12'h099, 1'b0, 1'b1, 1'b1);
        probe("R7 flags stored as given", 9, 12'h099);
        cyc_wr = 1'b1;
        probe("R10 ack ignores write-through in user mode", 9, 12'h099);
        write(10, 12'h0AA, 1'b1, 1'b0, 1'b0);
        ack_en = 1'b0;
        probe("R10 enable low gives no ack", 10, 12'h0AA);
        probe("R3 user mode mismatch", 10, 12'h0AB);
        @(negedge clk);
        wait (exp_q.size() == 0);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule